// File: doc/BRIEF.md
# Doubleword Load/Store Execution Unit

This unit executes the three memory instructions that a 64-bit RISC-V base integer core adds on top of the 32-bit set. These are the unsigned word load, the doubleword load and the doubleword store. The pipeline hands it a 32-bit instruction word, both source operand values and a valid strobe. The unit decodes the instruction and forms the effective address from the base operand and the sign-extended 12-bit offset. It then drives one request on a synchronous 64-bit memory port. For loads, it waits for read data, extends it and returns a single-cycle register writeback.

A four-state machine controls the sequencing:

- **ST_IDLE**: the unit accepts a new instruction.
  - A legal instruction moves it to ST_REQ (transition *accept*).
  - An unrecognised instruction keeps it in ST_IDLE and pulses the illegal flag (transition *reject*).
- **ST_REQ**: the memory request is driven for exactly one cycle. The unit always moves on to ST_WAIT (transition *issue*).
- **ST_WAIT**: the unit holds until the memory ready strobe arrives.
  - A load then moves to ST_WB (transition *load_done*).
  - A store returns straight to ST_IDLE (transition *store_done*).
- **ST_WB**: the writeback is presented for one cycle. The unit then returns to ST_IDLE (transition *retire*).

Top module: `ldst64_unit`

## Requirements
- R1: After reset, in_ready is 1 and mem_req, wb_en and illegal are all 0.
- R2: The recognised instructions are:
  - opcode bits[6:0]=0000011 with funct3 bits[14:12]=110: unsigned word load.
  - opcode 0000011 with funct3 011: doubleword load.
  - opcode 0100011 with funct3 011: doubleword store.

  Any other pair that is accepted raises illegal for exactly the next cycle. In that case there is no mem_req, and in_ready stays 1.
- R3: mem_addr is rs1_val plus the sign-extended 12-bit offset, modulo 2^64. Loads take the offset from instr[31:20]. Stores take it from {instr[31:25], instr[11:7]}.
- R4: An instruction is accepted only when in_valid and in_ready are both 1. in_ready is 1 only in ST_IDLE, and in_valid is ignored in every other state. mem_req is 1 in exactly the one cycle after acceptance. The unit waits in ST_WAIT for any number of cycles until mem_ready is 1.
- R5: Unsigned word load:
  - mem_be is 8'h0F when mem_addr[2]=0 and 8'hF0 when mem_addr[2]=1.
  - wb_data is the selected 32-bit half of mem_rdata (low half for 0, high half for 1), zero-extended to 64 bits.
- R6: Doubleword load: mem_be is 8'hFF and wb_data equals the full mem_rdata captured with mem_ready.
- R7: Doubleword store: mem_we is 1, mem_be is 8'hFF and mem_wdata equals rs2_val. Loads drive mem_we to 0.
- R8: wb_en is 1 for one cycle in ST_WB, and only when the load's rd field instr[11:7] is nonzero. wb_rd then carries that field. A store never raises wb_en.
- R9: mem_addr, mem_be, mem_we and mem_wdata hold steady from the request cycle through every cycle of ST_WAIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| rs1_val | input | 64 | Base operand |
| rs2_val | input | 64 | Store data operand |
| in_ready | output | 1 | Unit idle, can accept |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Effective byte address |
| mem_be | output | 8 | Byte lane enables |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Memory done; read data valid |
| mem_rdata | input | 64 | Read data |
| wb_en | output | 1 | Register writeback strobe |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Writeback value |
| illegal | output | 1 | One-cycle illegal-instruction pulse |

## Verification
Each result has a fixed distance from the clock edge that causes it:

- The request appears one cycle after the accepting edge.
- The illegal pulse also appears one cycle after the accepting edge.
- The writeback appears one cycle after the edge that sees mem_ready.
- For a store, in_ready returns one cycle after that same edge.

The bench drives stimulus on the falling edge and samples on the next falling edge after each causing edge. Because of that, every check lands exactly in the cycle its result is due. Stall cycles inserted before mem_ready are checked one by one for a low request and unchanged port values.

// File: rtl/ldst64_pkg.sv
package ldst64_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } ldst_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LWU  = 2'd1,
        OP_LD   = 2'd2,
        OP_SD   = 2'd3
    } ldst_op_e;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [2:0] F3_WORD_U = 3'b110;
    localparam logic [2:0] F3_DOUBLE = 3'b011;

endpackage

// File: rtl/ldst64_decode.sv
module ldst64_decode
    import ldst64_pkg::*;
#(
    parameter int ILEN  = 32,
    parameter int XLEN  = 64,
    parameter int IMM_W = 12,
    parameter int IDX_W = 5
) (
    input  logic [ILEN-1:0]  instr,
    output ldst_op_e         op,
    output logic [XLEN-1:0]  imm,
    output logic [IDX_W-1:0] rd
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [6:0]       opcode;
    logic [2:0]       funct3;
    logic [IMM_W-1:0] imm_raw;
    logic [4:0]       unused_base_idx;

    assign opcode          = instr[6:0];
    assign funct3          = instr[14:12];
    assign rd              = instr[11:7];
    assign unused_base_idx = instr[19:15];

    // stores split the offset across two fields
    assign imm_raw = (opcode == OPC_STORE) ? {instr[31:25], instr[11:7]}
                                           : instr[31:20];
    assign imm     = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};

    always_comb begin
        op = OP_NONE;
        if (opcode == OPC_LOAD && funct3 == F3_WORD_U)
            op = OP_LWU;
        else if (opcode == OPC_LOAD && funct3 == F3_DOUBLE)
            op = OP_LD;
        else if (opcode == OPC_STORE && funct3 == F3_DOUBLE)
            op = OP_SD;
    end

endmodule

// File: rtl/ldst64_agu.sv
module ldst64_agu #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] eff_addr
);
    // wraps modulo 2^XLEN
    assign eff_addr = base + offset;

endmodule

// File: rtl/ldst64_extend.sv
module ldst64_extend #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rdata,
    input  logic            half_sel,
    input  logic            word_mode,
    output logic [XLEN-1:0] result
);
    localparam int HALF_W   = XLEN / 2;
    localparam int N_HALVES = 2;

    logic [HALF_W-1:0] lane [N_HALVES];

    for (genvar g = 0; g < N_HALVES; g++) begin : g_lane
        assign lane[g] = rdata[g*HALF_W +: HALF_W];
    end

    assign result = word_mode ? {{HALF_W{1'b0}}, lane[half_sel]} : rdata;

endmodule

// File: rtl/ldst64_unit.sv
module ldst64_unit
    import ldst64_pkg::*;
#(
    parameter int ILEN  = 32,
    parameter int XLEN  = 64,
    parameter int IMM_W = 12,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ILEN-1:0]   instr,
    input  logic [XLEN-1:0]   rs1_val,
    input  logic [XLEN-1:0]   rs2_val,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN/8-1:0] mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_ready,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_rd,
    output logic [XLEN-1:0]   wb_data,
    output logic              illegal
);
    localparam int BYTES    = XLEN / 8;
    localparam int HB       = BYTES / 2;
    localparam int HALF_BIT = $clog2(BYTES) - 1;

    ldst_state_e      state_q, state_d;
    ldst_op_e         dec_op, op_q;
    logic [XLEN-1:0]  dec_imm, ea;
    logic [IDX_W-1:0] dec_rd, rd_q;
    logic [XLEN-1:0]  addr_q, wdata_q, ext_data, wbdata_q;
    logic             illegal_q;
    logic             accept;

    ldst64_decode #(
        .ILEN(ILEN), .XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)
    ) u_decode (
        .instr (instr),
        .op    (dec_op),
        .imm   (dec_imm),
        .rd    (dec_rd)
    );

    ldst64_agu #(.XLEN(XLEN)) u_agu (
        .base     (rs1_val),
        .offset   (dec_imm),
        .eff_addr (ea)
    );

    ldst64_extend #(.XLEN(XLEN)) u_extend (
        .rdata     (mem_rdata),
        .half_sel  (addr_q[HALF_BIT]),
        .word_mode (op_q == OP_LWU),
        .result    (ext_data)
    );

    assign accept = in_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && dec_op != OP_NONE) state_d = ST_REQ;
            ST_REQ:  state_d = ST_WAIT;
            ST_WAIT: if (mem_ready) state_d = (op_q == OP_SD) ? ST_IDLE : ST_WB;
            ST_WB:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // captured instruction context and load result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_NONE;
            rd_q      <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            wbdata_q  <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= accept && (dec_op == OP_NONE);
            if (accept && dec_op != OP_NONE) begin
                op_q    <= dec_op;
                rd_q    <= dec_rd;
                addr_q  <= ea;
                wdata_q <= rs2_val;
            end
            if (state_q == ST_WAIT && mem_ready)
                wbdata_q <= ext_data;
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        wb_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready = 1'b1;
            ST_REQ:  mem_req  = 1'b1;
            ST_WAIT: ;
            ST_WB:   wb_en    = (rd_q != '0);
            default: ;
        endcase
        mem_we    = (op_q == OP_SD);
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        wb_rd     = rd_q;
        wb_data   = wbdata_q;
        illegal   = illegal_q;
        unique case (op_q)
            OP_LWU:  mem_be = addr_q[HALF_BIT] ? {{HB{1'b1}}, {HB{1'b0}}}
                                               : {{HB{1'b0}}, {HB{1'b1}}};
            OP_LD:   mem_be = '1;
            OP_SD:   mem_be = '1;
            default: mem_be = '0;
        endcase
    end

    AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_op != OP_NONE) |=> mem_req);                         // R4
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);                                              // R4
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && in_ready));                                // R2
    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_op == OP_NONE) |=> illegal);                         // R2
    AST_PORT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> ($stable(mem_addr) && $stable(mem_be)
                                  && $stable(mem_we) && $stable(mem_wdata))); // R9
    AST_STORE_FULL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be == '1));                            // R7
    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !wb_en);                                                  // R8
    AST_WB_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (!mem_we && wb_rd != '0));                                // R8
    AST_WORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && op_q == OP_LWU) |-> ($countones(mem_be) == HB));        // R5

endmodule

// File: tb/tb_ldst64_unit.sv
`timescale 1ns/1ps
module tb_ldst64_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rs1_val = '0, rs2_val = '0;
    logic        in_ready, mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic [7:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        wb_en, illegal;
    logic [4:0]  wb_rd;
    logic [63:0] wb_data;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    ldst64_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_rd(wb_rd),
        .wb_data(wb_data), .illegal(illegal)
    );

    // kind: 0 unsigned word load, 1 doubleword load, 2 doubleword store
    typedef struct packed {
        logic [1:0]  kind;
        logic [11:0] imm;
        logic [4:0]  rd;
        logic [63:0] rs1;
        logic [63:0] rs2;
        logic [63:0] rdata;
        logic [63:0] addr;
        logic [7:0]  be;
        logic [63:0] wb;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 12'h008, 5'd5,  64'h1000, 64'h0, 64'hDEADBEEF_12345678,
          64'h1008, 8'h0F, 64'h00000000_12345678, 2'd0},
        '{2'd0, 12'h004, 5'd6,  64'h2000, 64'h0, 64'h87654321_00000001,
          64'h2004, 8'hF0, 64'h00000000_87654321, 2'd1},
        '{2'd0, 12'hFFC, 5'd7,  64'h3000, 64'h0, 64'hFFFFFFFF_00000000,
          64'h2FFC, 8'hF0, 64'h00000000_FFFFFFFF, 2'd0},
        '{2'd1, 12'h7FF, 5'd8,  64'h1_00000000, 64'h0, 64'hFEDCBA98_76543210,
          64'h1_000007FF, 8'hFF, 64'hFEDCBA98_76543210, 2'd2},
        '{2'd1, 12'h800, 5'd31, 64'h10000, 64'h0, 64'h01234567_89ABCDEF,
          64'hF800, 8'hFF, 64'h01234567_89ABCDEF, 2'd0},
        '{2'd1, 12'hFFF, 5'd3,  64'h0, 64'h0, 64'hA5A5A5A5_5A5A5A5A,
          64'hFFFFFFFF_FFFFFFFF, 8'hFF, 64'hA5A5A5A5_5A5A5A5A, 2'd0},
        '{2'd1, 12'h010, 5'd0,  64'h100, 64'h0, 64'h11112222_33334444,
          64'h110, 8'hFF, 64'h0, 2'd0},
        '{2'd2, 12'h010, 5'd0,  64'h4000, 64'hCAFEF00D_DEADBEEF, 64'h0,
          64'h4010, 8'hFF, 64'h0, 2'd0},
        '{2'd2, 12'hFF8, 5'd0,  64'h5000, 64'h80000000_00000001, 64'h0,
          64'h4FF8, 8'hFF, 64'h0, 2'd3},
        '{2'd2, 12'h7E1, 5'd0,  64'h0, 64'h01234567_89ABCDEF, 64'h0,
          64'h7E1, 8'hFF, 64'h0, 2'd0}
    };

    function automatic logic [31:0] enc(input logic [1:0] kind,
                                        input logic [11:0] imm,
                                        input logic [4:0] rd);
        case (kind)
            2'd0:    enc = {imm, 5'd1, 3'b110, rd, 7'b0000011};
            2'd1:    enc = {imm, 5'd1, 3'b011, rd, 7'b0000011};
            default: enc = {imm[11:5], 5'd2, 5'd1, 3'b011, imm[4:0], 7'b0100011};
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        string lr;
        lr = (v.kind == 2'd0) ? "R5" : (v.kind == 2'd1) ? "R6" : "R7";
        @(negedge clk);
        chk("R4 ready before accept", {63'd0, in_ready}, 64'd1);
        in_valid = 1'b1;
        instr    = enc(v.kind, v.imm, v.rd);
        rs1_val  = v.rs1;
        rs2_val  = v.rs2;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 request one cycle after accept", {63'd0, mem_req}, 64'd1);
        chk("R3 effective address", mem_addr, v.addr);
        chk({lr, " byte enables"}, {56'd0, mem_be}, {56'd0, v.be});
        chk("R7 write flag", {63'd0, mem_we}, {63'd0, v.kind == 2'd2});
        if (v.kind == 2'd2) chk("R7 write data", mem_wdata, v.rs2);
        for (int s = 0; s < int'(v.stall); s++) begin
            @(negedge clk);
            chk("R4 request dropped while waiting", {63'd0, mem_req}, 64'd0);
            chk("R9 address held in wait", mem_addr, v.addr);
            chk("R9 enables held in wait", {56'd0, mem_be}, {56'd0, v.be});
        end
        @(negedge clk);
        mem_ready = 1'b1;
        mem_rdata = v.rdata;
        @(negedge clk);
        mem_ready = 1'b0;
        mem_rdata = '0;
        if (v.kind == 2'd2) begin
            chk("R8 store gives no writeback", {63'd0, wb_en}, 64'd0);
            chk("R4 store returns to idle", {63'd0, in_ready}, 64'd1);
        end else begin
            chk("R8 writeback strobe", {63'd0, wb_en}, {63'd0, v.rd != 5'd0});
            if (v.rd != 5'd0) begin
                chk("R8 writeback index", {59'd0, wb_rd}, {59'd0, v.rd});
                chk({lr, " writeback data"}, wb_data, v.wb);
            end
            @(negedge clk);
            chk("R8 writeback lasts one cycle", {63'd0, wb_en}, 64'd0);
            chk("R4 load returns to idle", {63'd0, in_ready}, 64'd1);
        end
    endtask

    task automatic try_illegal(input logic [31:0] word);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = word;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 illegal pulse", {63'd0, illegal}, 64'd1);
        chk("R2 no request on illegal", {63'd0, mem_req}, 64'd0);
        chk("R2 still ready", {63'd0, in_ready}, 64'd1);
        @(negedge clk);
        chk("R2 illegal is one cycle", {63'd0, illegal}, 64'd0);
        chk("R2 no request after illegal", {63'd0, mem_req}, 64'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_errors++;
            $display("FAIL R4: watchdog expired, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready after reset", {63'd0, in_ready}, 64'd1);
        chk("R1 no request after reset", {63'd0, mem_req}, 64'd0);
        chk("R1 no writeback after reset", {63'd0, wb_en}, 64'd0);
        chk("R1 no illegal after reset", {63'd0, illegal}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2 rejected encodings
        try_illegal(32'h002081B3);                                   // register add
        try_illegal({12'h008, 5'd1, 3'b010, 5'd4, 7'b0000011});      // signed word load
        try_illegal({7'd0, 5'd2, 5'd1, 3'b010, 5'd0, 7'b0100011});   // word store

        // R4 in_valid ignored while busy
        @(negedge clk);
        in_valid = 1'b1;
        instr    = enc(2'd1, 12'h020, 5'd9);
        rs1_val  = 64'h8000;
        @(negedge clk);
        instr    = enc(2'd2, 12'h040, 5'd0);
        rs1_val  = 64'h9000;
        rs2_val  = 64'h5555;
        @(negedge clk);
        chk("R4 not ready while waiting", {63'd0, in_ready}, 64'd0);
        chk("R4 second strobe ignored", {63'd0, mem_req}, 64'd0);
        chk("R9 address unchanged by ignored strobe", mem_addr, 64'h8020);
        in_valid  = 1'b0;
        mem_ready = 1'b1;
        mem_rdata = 64'h0BADCAFE_0BADCAFE;
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R6 writeback of first load", wb_data, 64'h0BADCAFE_0BADCAFE);
        chk("R7 no write issued", {63'd0, mem_we}, 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R4 no request from dropped strobe", {63'd0, mem_req}, 64'd0);

        // R1 reset mid-operation
        in_valid = 1'b1;
        instr    = enc(2'd1, 12'h000, 5'd2);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 ready after mid-flight reset", {63'd0, in_ready}, 64'd1);
        chk("R1 request cleared by reset", {63'd0, mem_req}, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule